// File: doc/BRIEF.md
# DMA Request Segmenter with Read Tag Tracking

This block sits between an application DMA engine and a packet formatter on a serial point-to-point link endpoint. It accepts one transfer at a time, described by a direction, a start byte address and a byte length. It cuts the transfer into a run of memory request descriptors. Each piece is bounded by the configured size cap for its direction, by the bytes still left in the transfer, and by the next 4 KB address page edge. Write pieces are posted and carry a data offset into the source buffer.

Each read piece takes the lowest free tag from a pool and records its segment in a per-tag table. The answers to one read may arrive as several partial completions, and answers to different reads may interleave. Completions are matched by tag and checked against the tracked remaining byte count and the expected low address bits. For good data, the block reports where the data belongs in the destination buffer. A completion with a failing status, or one that does not match the tracked state, closes that tag and marks the transfer as failed. The transfer ends with a one-cycle done pulse that carries the error flag.

Top module: `rqseg_top`

## Requirements
- R1: A read piece is never longer than the read size cap. The cap for select value s is 128 << s bytes for s = 0..4, and 4096 bytes for s >= 5. The select is sampled when the transfer is accepted.
- R2: A write piece is never longer than the write size cap. The write cap uses the same select encoding as R1, taken from the write select input.
- R3: Each piece has length min(cap, bytes left, 4096 - (address mod 4096)). Pieces are contiguous, start at the transfer address, never cross a 4 KB edge, and carry their byte offset from the transfer start in `req_offset`.
- R4: Each read piece carries the lowest-numbered tag not currently in flight. While all 32 tags are in flight, `req_valid` stays low for reads.
- R5: A completion whose tag is not in flight is ignored. It produces no placement, frees nothing and sets no error.
- R6: A good completion for tag t requires three things: status 0, `cpl_byte_count` equal to t's remaining bytes, and `cpl_lower_addr` equal to bits [6:0] of the address of t's next unreceived byte. Its `cpl_dlen` must be nonzero and no larger than the remaining bytes. For such a completion, `place_valid` is high in the same cycle, and `place_offset` equals the segment offset plus the bytes of that segment already received. The remaining count then drops by `cpl_dlen`, and the tag is freed when it reaches zero.
- R7: A completion for an in-flight tag that fails R6 frees the tag and sets the transfer's error flag. Failure cases include Unsupported Request (status 1), Completer Abort (status 4), any other nonzero status, or a byte count or low address mismatch. No placement is reported for it.
- R8: For a read transfer, `xfer_done` pulses for one cycle, two cycles after the edge on which the last in-flight tag is freed, once every piece has been issued.
- R9: Write pieces use no tag (`req_tag` reads 0). `xfer_done` pulses in the cycle after the last write piece is accepted.
- R10: A transfer of zero bytes issues no pieces. `xfer_done` and `xfer_err` are both high in the cycle after it is accepted.
- R11: After reset and whenever no transfer is active, `xfer_ready` is high and `req_valid`, `place_valid` and `xfer_done` are low. `xfer_err` is only high together with `xfer_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xfer_valid | input | 1 | Transfer request present |
| xfer_ready | output | 1 | Block idle, transfer accepted this cycle if valid |
| xfer_write | input | 1 | 1 = write transfer, 0 = read transfer |
| xfer_addr | input | ADDR_W | Transfer start byte address |
| xfer_len | input | LEN_W | Transfer byte length |
| cfg_rd_sel | input | 3 | Read size cap select |
| cfg_wr_sel | input | 3 | Write size cap select |
| req_valid | output | 1 | Piece descriptor valid |
| req_ready | input | 1 | Downstream accepts the piece |
| req_write | output | 1 | Piece direction |
| req_addr | output | ADDR_W | Piece start address |
| req_len | output | 13 | Piece byte length |
| req_tag | output | TAG_W | Read tag (0 for writes) |
| req_offset | output | LEN_W | Piece offset from transfer start |
| cpl_valid | input | 1 | Completion descriptor present |
| cpl_tag | input | TAG_W | Completion tag |
| cpl_status | input | 3 | Completion status (0 success, 1 UR, 4 CA) |
| cpl_byte_count | input | 13 | Bytes still owed for the request, this one included |
| cpl_lower_addr | input | 7 | Low address bits of the first byte carried |
| cpl_dlen | input | 13 | Payload bytes carried |
| place_valid | output | 1 | Good completion data to place |
| place_offset | output | LEN_W | Destination offset for that data |
| xfer_done | output | 1 | Transfer finished (one-cycle pulse) |
| xfer_err | output | 1 | Transfer failed (valid with xfer_done) |

## Verification
The assertions assume that completions only arrive for requests the block issued, or carry a tag that is plainly free. They also assume that the size selects and `req_ready` are plain levels with no relation to an assertion's window. The bench keeps to this: it derives every completion from its own record of open tags, splits replies on 64-byte lines as a real completer would, and drives strays only with free tags. Error injection changes exactly one field of one otherwise well-formed completion per run. Backpressure follows a fixed cycle pattern, so stalls from a full tag pool and from a busy downstream both occur.

// File: rtl/rqseg_pkg.sv
package rqseg_pkg;

  localparam int SEG_W  = 13;   // piece length, up to 4096
  localparam int LOWA_W = 7;    // completion low address width
  localparam int PAGE   = 4096;

  localparam logic [2:0] CPL_OK = 3'd0;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_DRAIN,
    ST_FIN
  } ctl_state_e;

  // size cap from a 3-bit select: 128 << sel, clamped at 4096
  function automatic logic [SEG_W-1:0] size_cap(input logic [2:0] sel);
    if (sel >= 3'd5) return SEG_W'(PAGE);
    return SEG_W'(128) << sel;
  endfunction

  // bytes from an address to the next page edge
  function automatic logic [SEG_W-1:0] to_page_edge(input logic [11:0] low);
    return SEG_W'(PAGE) - {1'b0, low};
  endfunction

  function automatic logic [SEG_W-1:0] min3(input logic [SEG_W-1:0] a,
                                            input logic [SEG_W-1:0] b,
                                            input logic [SEG_W-1:0] c);
    logic [SEG_W-1:0] m;
    m = (a < b) ? a : b;
    return (m < c) ? m : c;
  endfunction

endpackage

// File: rtl/rqseg_split.sv
module rqseg_split
  import rqseg_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              ld_write,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [LEN_W-1:0]  ld_len,
  input  logic [2:0]        ld_rd_sel,
  input  logic [2:0]        ld_wr_sel,
  input  logic              step,
  output logic [ADDR_W-1:0] seg_addr,
  output logic [SEG_W-1:0]  seg_len,
  output logic [LEN_W-1:0]  seg_off,
  output logic              seg_write,
  output logic              seg_last
);

  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  left_q;
  logic [LEN_W-1:0]  off_q;
  logic              wr_q;
  logic [2:0]        sel_q;
  logic [SEG_W-1:0]  cap_q;
  logic [SEG_W-1:0]  left_clip;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      left_q <= '0;
      off_q  <= '0;
      wr_q   <= 1'b0;
      sel_q  <= '0;
      cap_q  <= '0;
    end else if (load) begin
      addr_q <= ld_addr;
      left_q <= ld_len;
      off_q  <= '0;
      wr_q   <= ld_write;
      sel_q  <= ld_write ? ld_wr_sel : ld_rd_sel;
      cap_q  <= size_cap(ld_write ? ld_wr_sel : ld_rd_sel);
    end else if (step) begin
      addr_q <= addr_q + ADDR_W'(seg_len);
      left_q <= left_q - LEN_W'(seg_len);
      off_q  <= off_q + LEN_W'(seg_len);
    end
  end

  always_comb begin
    left_clip = (left_q >= LEN_W'(PAGE)) ? SEG_W'(PAGE) : left_q[SEG_W-1:0];
    seg_len   = min3(cap_q, left_clip, to_page_edge(addr_q[11:0]));
    seg_last  = (left_q == LEN_W'(seg_len));
  end

  assign seg_addr  = addr_q;
  assign seg_off   = off_q;
  assign seg_write = wr_q;

  // cap restated as a right shift of the page size
  logic [SEG_W-1:0] alt_cap;
  assign alt_cap = (sel_q >= 3'd5) ? SEG_W'(PAGE) : (SEG_W'(PAGE) >> (3'd5 - sel_q));

  a_r1_read_cap: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !wr_q) |-> (seg_len <= alt_cap && seg_len != '0));

  a_r2_write_cap: assert property (@(posedge clk) disable iff (!rst_n)
    (step && wr_q) |-> (seg_len <= alt_cap && seg_len != '0));

  a_r3_no_cross: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (({1'b0, addr_q[11:0]} + seg_len) <= SEG_W'(PAGE)));

  a_r3_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !seg_last) |=> (addr_q == $past(addr_q) + ADDR_W'($past(seg_len))));

endmodule

// File: rtl/rqseg_tagpool.sv
module rqseg_tagpool #(
  parameter int TAGS  = 32,
  parameter int TAG_W = $clog2(TAGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc,
  input  logic             rel,
  input  logic [TAG_W-1:0] rel_tag,
  output logic [TAG_W-1:0] alloc_tag,
  output logic             free_any,
  output logic             all_free,
  output logic [TAGS-1:0]  free_vec
);

  logic [TAGS-1:0] free_q;
  logic [TAGS-1:0] clr_vec;
  logic [TAGS-1:0] set_vec;

  // lowest free tag wins
  always_comb begin
    alloc_tag = '0;
    for (int i = TAGS - 1; i >= 0; i--) begin
      if (free_q[i]) alloc_tag = TAG_W'(i);
    end
  end

  assign clr_vec  = alloc ? (TAGS'(1) << alloc_tag) : '0;
  assign set_vec  = rel   ? (TAGS'(1) << rel_tag)   : '0;
  assign free_any = |free_q;
  assign all_free = &free_q;
  assign free_vec = free_q;

  always_ff @(posedge clk) begin
    if (!rst_n) free_q <= '1;
    else        free_q <= (free_q & ~clr_vec) | set_vec;
  end

  a_r4_alloc_from_free: assert property (@(posedge clk) disable iff (!rst_n)
    alloc |-> free_q[alloc_tag]);

  a_r4_alloc_takes: assert property (@(posedge clk) disable iff (!rst_n)
    alloc |=> !free_q[$past(alloc_tag)]);

  a_r5_release_busy: assert property (@(posedge clk) disable iff (!rst_n)
    rel |-> !free_q[rel_tag]);

endmodule

// File: rtl/rqseg_cpltab.sv
module rqseg_cpltab
  import rqseg_pkg::*;
#(
  parameter int TAGS  = 32,
  parameter int TAG_W = $clog2(TAGS),
  parameter int LEN_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [SEG_W-1:0]  wr_len,
  input  logic [LEN_W-1:0]  wr_off,
  input  logic [LOWA_W-1:0] wr_lowa,
  input  logic [TAGS-1:0]   busy,
  input  logic              cpl_valid,
  input  logic [TAG_W-1:0]  cpl_tag,
  input  logic [2:0]        cpl_status,
  input  logic [SEG_W-1:0]  cpl_byte_count,
  input  logic [LOWA_W-1:0] cpl_lower_addr,
  input  logic [SEG_W-1:0]  cpl_dlen,
  output logic              place_valid,
  output logic [LEN_W-1:0]  place_offset,
  output logic              rel,
  output logic [TAG_W-1:0]  rel_tag,
  output logic              err_evt
);

  logic [SEG_W-1:0]  rem_q  [TAGS];
  logic [SEG_W-1:0]  len_q  [TAGS];
  logic [LEN_W-1:0]  off_q  [TAGS];
  logic [LOWA_W-1:0] lowa_q [TAGS];

  logic              hit;
  logic              bad;
  logic              good;
  logic [SEG_W-1:0]  rem_c;
  logic [SEG_W-1:0]  got_c;
  logic [SEG_W-1:0]  rem_next;
  logic [LOWA_W-1:0] exp_lowa;

  always_comb begin
    hit      = cpl_valid && busy[cpl_tag];
    rem_c    = rem_q[cpl_tag];
    got_c    = len_q[cpl_tag] - rem_c;
    exp_lowa = lowa_q[cpl_tag] + got_c[LOWA_W-1:0];
    bad      = (cpl_status != CPL_OK)
            || (cpl_byte_count != rem_c)
            || (cpl_lower_addr != exp_lowa)
            || (cpl_dlen == '0)
            || (cpl_dlen > rem_c);
    good     = hit && !bad;
    rem_next = rem_c - cpl_dlen;
  end

  assign err_evt      = hit && bad;
  assign place_valid  = good;
  assign place_offset = off_q[cpl_tag] + LEN_W'(got_c);
  assign rel          = err_evt || (good && rem_next == '0);
  assign rel_tag      = cpl_tag;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < TAGS; i++) begin
        rem_q[i]  <= '0;
        len_q[i]  <= '0;
        off_q[i]  <= '0;
        lowa_q[i] <= '0;
      end
    end else begin
      if (wr_en) begin
        rem_q[wr_tag]  <= wr_len;
        len_q[wr_tag]  <= wr_len;
        off_q[wr_tag]  <= wr_off;
        lowa_q[wr_tag] <= wr_lowa;
      end
      if (good) rem_q[cpl_tag] <= rem_next;
    end
  end

  a_r5_stray_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_valid && !busy[cpl_tag]) |-> (!place_valid && !rel && !err_evt));

  a_r6_partial_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (place_valid && !rel) |=> (rem_q[$past(cpl_tag)] == $past(rem_c) - $past(cpl_dlen)));

endmodule

// File: rtl/rqseg_top.sv
module rqseg_top
  import rqseg_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16,
  parameter int TAGS   = 32,
  parameter int TAG_W  = $clog2(TAGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xfer_valid,
  output logic              xfer_ready,
  input  logic              xfer_write,
  input  logic [ADDR_W-1:0] xfer_addr,
  input  logic [LEN_W-1:0]  xfer_len,
  input  logic [2:0]        cfg_rd_sel,
  input  logic [2:0]        cfg_wr_sel,
  output logic              req_valid,
  input  logic              req_ready,
  output logic              req_write,
  output logic [ADDR_W-1:0] req_addr,
  output logic [12:0]       req_len,
  output logic [TAG_W-1:0]  req_tag,
  output logic [LEN_W-1:0]  req_offset,
  input  logic              cpl_valid,
  input  logic [TAG_W-1:0]  cpl_tag,
  input  logic [2:0]        cpl_status,
  input  logic [12:0]       cpl_byte_count,
  input  logic [6:0]        cpl_lower_addr,
  input  logic [12:0]       cpl_dlen,
  output logic              place_valid,
  output logic [LEN_W-1:0]  place_offset,
  output logic              xfer_done,
  output logic              xfer_err
);

  ctl_state_e state_q;
  logic       err_q;

  // named internal events
  logic              start;
  logic              start_zero;
  logic              fire;
  logic              alloc;
  logic              err_evt;
  logic              rel;
  logic [TAG_W-1:0]  rel_tag;
  logic [TAG_W-1:0]  alloc_tag;
  logic              free_any;
  logic              all_free;
  logic [TAGS-1:0]   free_vec;
  logic [ADDR_W-1:0] seg_addr;
  logic [SEG_W-1:0]  seg_len;
  logic [LEN_W-1:0]  seg_off;
  logic              seg_write;
  logic              seg_last;

  assign xfer_ready = (state_q == ST_IDLE);
  assign start      = xfer_valid && xfer_ready;
  assign start_zero = start && (xfer_len == '0);
  assign req_valid  = (state_q == ST_ISSUE) && (seg_write || free_any);
  assign fire       = req_valid && req_ready;
  assign alloc      = fire && !seg_write;

  assign req_write  = seg_write;
  assign req_addr   = seg_addr;
  assign req_len    = seg_len;
  assign req_offset = seg_off;
  assign req_tag    = seg_write ? '0 : alloc_tag;

  assign xfer_done  = (state_q == ST_FIN);
  assign xfer_err   = xfer_done && err_q;

  rqseg_split #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_split (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (start),
    .ld_write  (xfer_write),
    .ld_addr   (xfer_addr),
    .ld_len    (xfer_len),
    .ld_rd_sel (cfg_rd_sel),
    .ld_wr_sel (cfg_wr_sel),
    .step      (fire),
    .seg_addr  (seg_addr),
    .seg_len   (seg_len),
    .seg_off   (seg_off),
    .seg_write (seg_write),
    .seg_last  (seg_last)
  );

  rqseg_tagpool #(.TAGS(TAGS), .TAG_W(TAG_W)) u_pool (
    .clk       (clk),
    .rst_n     (rst_n),
    .alloc     (alloc),
    .rel       (rel),
    .rel_tag   (rel_tag),
    .alloc_tag (alloc_tag),
    .free_any  (free_any),
    .all_free  (all_free),
    .free_vec  (free_vec)
  );

  rqseg_cpltab #(.TAGS(TAGS), .TAG_W(TAG_W), .LEN_W(LEN_W)) u_tab (
    .clk            (clk),
    .rst_n          (rst_n),
    .wr_en          (alloc),
    .wr_tag         (alloc_tag),
    .wr_len         (seg_len),
    .wr_off         (seg_off),
    .wr_lowa        (seg_addr[LOWA_W-1:0]),
    .busy           (~free_vec),
    .cpl_valid      (cpl_valid),
    .cpl_tag        (cpl_tag),
    .cpl_status     (cpl_status),
    .cpl_byte_count (cpl_byte_count),
    .cpl_lower_addr (cpl_lower_addr),
    .cpl_dlen       (cpl_dlen),
    .place_valid    (place_valid),
    .place_offset   (place_offset),
    .rel            (rel),
    .rel_tag        (rel_tag),
    .err_evt        (err_evt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      err_q   <= 1'b0;
    end else begin
      if (start)        err_q <= start_zero;
      else if (err_evt) err_q <= 1'b1;
      unique case (state_q)
        ST_IDLE:  if (start) state_q <= start_zero ? ST_FIN : ST_ISSUE;
        ST_ISSUE: if (fire && seg_last) state_q <= seg_write ? ST_FIN : ST_DRAIN;
        ST_DRAIN: if (all_free) state_q <= ST_FIN;
        ST_FIN:   state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  a_r10_zero_reject: assert property (@(posedge clk) disable iff (!rst_n)
    start_zero |=> (xfer_done && xfer_err && !req_valid));

  a_r7_err_frees_tag: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_valid && cpl_status != CPL_OK && !free_vec[cpl_tag]) |=>
      (free_vec[$past(cpl_tag)] && (err_q || xfer_done)));

  a_r9_write_done: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && seg_write && seg_last) |=> xfer_done);

  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_ready |-> (!req_valid && !xfer_done));

endmodule

// File: tb/test_rqseg_top.sv
`timescale 1ns/1ps
module test_rqseg_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        xfer_valid = 1'b0;
  logic        xfer_ready;
  logic        xfer_write = 1'b0;
  logic [31:0] xfer_addr = '0;
  logic [15:0] xfer_len = '0;
  logic [2:0]  cfg_rd_sel = '0;
  logic [2:0]  cfg_wr_sel = '0;
  logic        req_valid;
  logic        req_ready = 1'b0;
  logic        req_write;
  logic [31:0] req_addr;
  logic [12:0] req_len;
  logic [4:0]  req_tag;
  logic [15:0] req_offset;
  logic        cpl_valid = 1'b0;
  logic [4:0]  cpl_tag = '0;
  logic [2:0]  cpl_status = '0;
  logic [12:0] cpl_byte_count = '0;
  logic [6:0]  cpl_lower_addr = '0;
  logic [12:0] cpl_dlen = '0;
  logic        place_valid;
  logic [15:0] place_offset;
  logic        xfer_done;
  logic        xfer_err;

  always #2 clk = ~clk;   // 250 MHz

  rqseg_top i_rqseg_top (
    .clk(clk), .rst_n(rst_n),
    .xfer_valid(xfer_valid), .xfer_ready(xfer_ready), .xfer_write(xfer_write),
    .xfer_addr(xfer_addr), .xfer_len(xfer_len),
    .cfg_rd_sel(cfg_rd_sel), .cfg_wr_sel(cfg_wr_sel),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_len(req_len), .req_tag(req_tag), .req_offset(req_offset),
    .cpl_valid(cpl_valid), .cpl_tag(cpl_tag), .cpl_status(cpl_status),
    .cpl_byte_count(cpl_byte_count), .cpl_lower_addr(cpl_lower_addr), .cpl_dlen(cpl_dlen),
    .place_valid(place_valid), .place_offset(place_offset),
    .xfer_done(xfer_done), .xfer_err(xfer_err)
  );

  int total = 0;
  int bad = 0;
  int gcyc = 0;
  bit finished = 1'b0;

  // reference model state, indexed by tag
  bit busy[32];
  int t_rem[32];
  int t_len[32];
  int t_off[32];
  int t_addr[32];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic int cap_of(input int sel);
    if (sel >= 5) return 4096;
    return 128 * (2 ** sel);
  endfunction

  function automatic int nbusy();
    int n = 0;
    for (int i = 0; i < 32; i++) if (busy[i]) n++;
    return n;
  endfunction

  function automatic int lowest_free();
    for (int i = 0; i < 32; i++) if (!busy[i]) return i;
    return -1;
  endfunction

  // inj: 0 none, 1 UR, 2 CA, 3 low address off by one, 4 byte count off by one
  task automatic run_xfer(input bit wr, input int addr, input int len,
                          input int rsel, input int wsel, input int gap, input int inj);
    int sa[$];
    int sl[$];
    int so[$];
    int a, left, off, lim, seg, idx, nseg, wait_cnt, ncpl, lcyc;
    bit exp_err, drained, saw_done;
    a = addr; left = len; off = 0;
    lim = wr ? cap_of(wsel) : cap_of(rsel);
    while (left > 0) begin
      seg = lim;
      if (left < seg) seg = left;
      if (4096 - (a % 4096) < seg) seg = 4096 - (a % 4096);
      sa.push_back(a); sl.push_back(seg); so.push_back(off);
      a += seg; left -= seg; off += seg;
    end
    nseg = sl.size();

    xfer_valid = 1'b1; xfer_write = wr; xfer_addr = 32'(addr); xfer_len = 16'(len);
    cfg_rd_sel = 3'(rsel); cfg_wr_sel = 3'(wsel);
    #1;
    chk(xfer_ready == 1'b1, "R11 ready before start", xfer_ready, 1);
    @(posedge clk); #1;
    gcyc++;
    xfer_valid = 1'b0;
    cfg_rd_sel = 3'd0; cfg_wr_sel = 3'd0;   // sampled at start only (R1)

    idx = 0; ncpl = 0; lcyc = 0;
    exp_err = (len == 0);
    wait_cnt = (len == 0) ? 1 : 0;
    drained = 1'b0; saw_done = 1'b0;

    while (!saw_done && lcyc < 20000 && !finished) begin
      int ct, cdl, pos;
      bit creal, cerr, stray, ev, ed, fire;
      int etag;
      // drive phase
      req_ready = ((gcyc % 5) != 2);
      creal = 1'b0; cerr = 1'b0; stray = 1'b0; ct = 0; cdl = 0; pos = 0;
      cpl_valid = 1'b0;
      if (nbusy() > 0 && (gcyc % gap) == 0) begin
        int lst[$];
        int cur;
        for (int i = 0; i < 32; i++) if (busy[i]) lst.push_back(i);
        ct = lst[gcyc % lst.size()];
        pos = t_len[ct] - t_rem[ct];
        cur = t_addr[ct] + pos;
        cdl = 64 - (cur % 64);
        if (t_rem[ct] < cdl) cdl = t_rem[ct];
        creal = 1'b1; ncpl++;
        cpl_valid = 1'b1; cpl_tag = 5'(ct); cpl_status = 3'd0;
        cpl_byte_count = 13'(t_rem[ct]); cpl_lower_addr = 7'(cur % 128); cpl_dlen = 13'(cdl);
        if (inj != 0 && ncpl == 3) begin
          cerr = 1'b1;
          case (inj)
            1: cpl_status = 3'd1;
            2: cpl_status = 3'd4;
            3: cpl_lower_addr = 7'((cur + 1) % 128);
            default: cpl_byte_count = 13'(t_rem[ct] + 1);
          endcase
        end
      end else if (nbusy() < 32 && (gcyc % 7) == 3) begin
        for (int i = 31; i >= 0; i--) if (!busy[i]) begin ct = i; break; end
        stray = 1'b1;
        cpl_valid = 1'b1; cpl_tag = 5'(ct); cpl_status = 3'd0;
        cpl_byte_count = 13'd64; cpl_lower_addr = 7'd0; cpl_dlen = 13'd64;
      end
      #1;
      // check phase
      ev = (idx < nseg) && (wr || nbusy() < 32);
      etag = wr ? 0 : lowest_free();
      if (!wr && idx < nseg && nbusy() == 32)
        chk(req_valid == 1'b0, "R4 stall with no free tag", req_valid, 0);
      else
        chk(req_valid == ev, "R3 req_valid", req_valid, ev);
      if (ev && req_valid) begin
        chk(req_addr == 32'(sa[idx]), "R3 piece address", req_addr, sa[idx]);
        chk(req_len == 13'(sl[idx]), wr ? "R2 write piece length" : "R1 read piece length", req_len, sl[idx]);
        chk(req_offset == 16'(so[idx]), "R3 piece offset", req_offset, so[idx]);
        chk(req_write == wr, "R3 piece direction", req_write, wr);
        chk(req_tag == 5'(etag), wr ? "R9 write tag zero" : "R4 lowest free tag", req_tag, etag);
      end
      if (creal && !cerr) begin
        chk(place_valid == 1'b1, "R6 place valid", place_valid, 1);
        chk(place_offset == 16'(t_off[ct] + pos), "R6 place offset", place_offset, t_off[ct] + pos);
      end else if (creal) begin
        chk(place_valid == 1'b0, "R7 no place on bad completion", place_valid, 0);
      end else if (stray) begin
        chk(place_valid == 1'b0, "R5 stray tag ignored", place_valid, 0);
      end else begin
        chk(place_valid == 1'b0, "R11 place idle", place_valid, 0);
      end
      ed = 1'b0;
      if (wait_cnt > 0) begin
        wait_cnt--;
        ed = (wait_cnt == 0);
      end
      chk(xfer_done == ed, wr ? "R9 done timing" : (len == 0 ? "R10 done timing" : "R8 done timing"), xfer_done, ed);
      if (ed) begin
        chk(xfer_err == exp_err, len == 0 ? "R10 error flag" : "R7 error flag", xfer_err, exp_err);
        saw_done = 1'b1;
      end else begin
        chk(xfer_err == 1'b0, "R11 err only with done", xfer_err, 0);
      end
      fire = ev && req_ready;
      @(posedge clk); #1;
      gcyc++; lcyc++;
      // model update
      if (creal) begin
        if (cerr) begin
          busy[ct] = 1'b0; exp_err = 1'b1;
        end else begin
          t_rem[ct] -= cdl;
          if (t_rem[ct] == 0) busy[ct] = 1'b0;
        end
      end
      if (fire) begin
        if (!wr) begin
          busy[etag] = 1'b1; t_rem[etag] = sl[idx]; t_len[etag] = sl[idx];
          t_off[etag] = so[idx]; t_addr[etag] = sa[idx];
        end
        idx++;
        if (idx == nseg && wr) wait_cnt = 1;
      end
      if (!wr && len != 0 && idx == nseg && nbusy() == 0 && !drained) begin
        drained = 1'b1; wait_cnt = 2;
      end
    end
    cpl_valid = 1'b0;
    if (!saw_done) chk(1'b0, "R8 transfer never finished", 0, 1);
    chk(xfer_ready == 1'b1, "R11 idle after done", xfer_ready, 1);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) busy[i] = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    #1;
    chk(xfer_ready == 1'b1, "R11 reset ready", xfer_ready, 1);
    chk(req_valid == 1'b0, "R11 reset req_valid", req_valid, 0);
    chk(xfer_done == 1'b0, "R11 reset done", xfer_done, 0);
    chk(place_valid == 1'b0, "R11 reset place", place_valid, 0);
    @(posedge clk); #1; gcyc++;

    run_xfer(1'b1, 32'h100, 1000, 0, 0, 1, 0);      // R2 writes at 128
    run_xfer(1'b1, 32'hFF0, 600, 0, 2, 1, 0);       // R3 write crossing a page
    run_xfer(1'b0, 32'h1F80, 9000, 5, 0, 1, 0);     // R3 read crossing pages
    run_xfer(1'b0, 32'h40, 20000, 0, 0, 4, 0);      // R4 pool exhaustion
    run_xfer(1'b0, 32'h0, 5000, 7, 0, 1, 0);        // R1 clamp of select 7
    run_xfer(1'b0, 32'h230, 1500, 1, 0, 1, 1);      // R7 UR
    run_xfer(1'b0, 32'h3010, 1200, 2, 0, 2, 2);     // R7 CA
    run_xfer(1'b0, 32'h77, 900, 3, 0, 1, 3);        // R6 low address mismatch
    run_xfer(1'b0, 32'h500, 700, 0, 0, 1, 4);       // R6 byte count mismatch
    run_xfer(1'b0, 32'h500, 0, 0, 0, 1, 0);         // R10 zero read
    run_xfer(1'b1, 32'h800, 0, 0, 0, 1, 0);         // R10 zero write
    run_xfer(1'b1, 32'h1000, 8192, 0, 6, 1, 0);     // R2 clamp of select 6
    run_xfer(1'b0, 32'hFFC, 10, 4, 0, 1, 0);        // R3 tiny read over a page edge

    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule